// File: doc/BRIEF.md
# Configurable-Trigger Two-Output Interrupt Controller

This block gathers 51 interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. Each line has a detector that is either level-sensitive or edge-sensitive. The detector sets a pending bit, which is then gated by a per-line enable and steered by a per-line route bit to one of the two outputs. The trigger type of every line is fixed at reset. The only exception is the polarity of the four highest lines, which software can change.

Software reaches the block through a plain 32-bit register port with separate read and write strobes. Each 51-bit quantity appears as a pair of words. The low word holds lines 31..0. The high word sits 4 bytes above it and holds lines 50..32 in its bits 18..0. Enable has separate write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. Latched edge events are dismissed through a separate write-one-to-clear word.

Top module: `vic_top`

## Requirements
- R1: Reset state. Pending, enable and route are all zero and both outputs are low. The fixed configuration reads as follows: sensitivity 0x1F07FFF8FFFF (1 = level), both-edge 0x00F800070000, polarity 0x5F07FFF8FFFF (1 = high or rising).
- R2: Word layout. Address bit 2 selects the high word. A high word carries bits 50..32 in bits 18..0 and reads zero in bits 31..19. Read data appears in the cycle after `rdEn`.
- R3: A level line (sensitivity 1) has a pending bit that follows the input one cycle later. The bit is set when the input is high if polarity is 1, and when the input is low if polarity is 0.
- R4: An edge line (sensitivity 0) without both-edge detects one edge only. With polarity 1 a rising edge sets the pending bit; with polarity 0 a falling edge sets it. The opposite edge has no effect.
- R5: An edge line with both-edge set sets its pending bit on any change of the input.
- R6: An edge pending bit stays set until a one is written to its position at 0xD8/0xDC. Ones written there for level lines have no effect.
- R7: Writing ones at 0xA0/0xA4 sets enable bits. Writing ones at 0xA8/0xAC clears them. Zero bits leave enable unchanged.
- R8: A write to the route word at 0x98/0x9C replaces only the addressed half, and the other half is kept. A route bit of 1 sends the line to the fast output.
- R9: Polarity is writable only for lines 50..47, through bits 18..15 of the high word at 0xD4. Writes to 0xD0 are ignored.
- R10: Status reads. 0x80 returns pending & enable & ~route, 0x88 returns pending & enable & route, 0x90 returns pending, and 0xE0 returns pending & ~sensitivity.
- R11: The normal output is the OR of pending & enable & ~route. The fast output is the OR of pending & enable & route. Both are registered and change in the cycle after the input or write that causes the change.
- R12: Reads of the write-only words (0xA8, 0xD8) and of offsets with no register return zero. Writes to the status, sensitivity and both-edge words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the register word |
| wrData | input | 32 | Write data |
| irqLines | input | 51 | Interrupt inputs, synchronous to clk |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Most of the configuration is fixed at reset, so the hardest situation to reach from the ports is an edge line whose detected edge has been changed by software. Only lines 50..47 allow that. The bench first rewrites their polarity through the high event word. It then pulses line 48 and confirms that the rising edge now latches and the falling edge does not. Single-cycle pulses on the falling line, the rising line and a both-edge line check that each edge is latched exactly once and survives until it is cleared explicitly.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  localparam int NUM_LINES = 51;
  localparam int DATA_W    = 32;
  localparam int HI_W      = NUM_LINES - DATA_W;
  localparam int ADDR_W    = 8;
  localparam int EVT_LO    = 47;

  localparam logic [NUM_LINES-1:0] SENSE_INIT = 51'h1F07FFF8FFFF;
  localparam logic [NUM_LINES-1:0] BOTH_INIT  = 51'h00F800070000;
  localparam logic [NUM_LINES-1:0] EVENT_INIT = 51'h5F07FFF8FFFF;

  typedef enum logic [3:0] {
    RD_NONE, RD_IRQ, RD_FIQ, RD_RAW, RD_SEL, RD_EN,
    RD_SENSE, RD_BOTH, RD_EVT, RD_EDGE
  } rdSel_e;

  typedef struct packed {
    logic   selWr;
    logic   enSet;
    logic   enClr;
    logic   evtWr;
    logic   edgeClr;
    logic   hiHalf;
    logic   rdStb;
    rdSel_e rdSel;
  } ctrl_t;
endpackage

// File: rtl/vic_regctl.sv
`timescale 1ns/1ps
module vic_regctl
  import vic_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrl_t             ctrl
);
  logic [ADDR_W-1:0] base;
  logic              inWin;

  assign base  = {addr[ADDR_W-1:3], 3'b000};
  assign inWin = addr[ADDR_W-1] && (addr[1:0] == 2'b00);

  always_comb begin
    ctrl        = '0;
    ctrl.rdSel  = RD_NONE;
    ctrl.hiHalf = addr[2];
    ctrl.rdStb  = rdEn;
    if (inWin) begin
      case (base)
        8'h80: ctrl.rdSel = RD_IRQ;
        8'h88: ctrl.rdSel = RD_FIQ;
        8'h90: ctrl.rdSel = RD_RAW;
        8'h98: begin ctrl.rdSel = RD_SEL; ctrl.selWr = wrEn; end
        8'hA0: begin ctrl.rdSel = RD_EN;  ctrl.enSet = wrEn; end
        8'hA8: ctrl.enClr = wrEn;
        8'hC0: ctrl.rdSel = RD_SENSE;
        8'hC8: ctrl.rdSel = RD_BOTH;
        8'hD0: begin ctrl.rdSel = RD_EVT; ctrl.evtWr = wrEn && addr[2]; end
        8'hD8: ctrl.edgeClr = wrEn;
        8'hE0: ctrl.rdSel = RD_EDGE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vic_datapath.sv
`timescale 1ns/1ps
module vic_datapath
  import vic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_t                ctrl,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic                 fiqOut,
  output logic [NUM_LINES-1:0] rawBits,
  output logic [NUM_LINES-1:0] enBits,
  output logic [NUM_LINES-1:0] selBits,
  output logic [NUM_LINES-1:0] senseBits,
  output logic [NUM_LINES-1:0] evtBits
);
  logic [NUM_LINES-1:0] wide, clrMask, rawNext, enNext, selNext, prevLvl, rdVal;

  assign senseBits = SENSE_INIT;
  assign wide = ctrl.hiHalf ? {wrData[HI_W-1:0], {DATA_W{1'b0}}}
                            : {{HI_W{1'b0}}, wrData};
  assign clrMask = ctrl.edgeClr ? (wide & ~SENSE_INIT) : '0;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic lvlHit, edgeHit;
    assign lvlHit  = ~(irqLines[i] ^ evtBits[i]);
    assign edgeHit = BOTH_INIT[i] ? (irqLines[i] ^ prevLvl[i])
                   : evtBits[i]   ? (irqLines[i] & ~prevLvl[i])
                                  : (~irqLines[i] & prevLvl[i]);
    assign rawNext[i] = SENSE_INIT[i] ? lvlHit
                                      : ((rawBits[i] & ~clrMask[i]) | edgeHit);
    if (i >= EVT_LO) begin : g_evtRw
      always_ff @(posedge clk) begin
        if (!rstN)           evtBits[i] <= EVENT_INIT[i];
        else if (ctrl.evtWr) evtBits[i] <= wide[i];
      end
    end else begin : g_evtRo
      assign evtBits[i] = EVENT_INIT[i];
    end
  end

  always_comb begin
    enNext = enBits;
    if (ctrl.enSet) enNext = enNext | wide;
    if (ctrl.enClr) enNext = enNext & ~wide;
    selNext = selBits;
    if (ctrl.selWr)
      selNext = ctrl.hiHalf ? {wide[NUM_LINES-1:DATA_W], selBits[DATA_W-1:0]}
                            : {selBits[NUM_LINES-1:DATA_W], wide[DATA_W-1:0]};
  end

  always_comb begin
    case (ctrl.rdSel)
      RD_IRQ:   rdVal = rawBits & enBits & ~selBits;
      RD_FIQ:   rdVal = rawBits & enBits & selBits;
      RD_RAW:   rdVal = rawBits;
      RD_SEL:   rdVal = selBits;
      RD_EN:    rdVal = enBits;
      RD_SENSE: rdVal = SENSE_INIT;
      RD_BOTH:  rdVal = BOTH_INIT;
      RD_EVT:   rdVal = evtBits;
      RD_EDGE:  rdVal = rawBits & ~SENSE_INIT;
      default:  rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawBits <= '0;
      enBits  <= '0;
      selBits <= '0;
      prevLvl <= '0;
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
      rdData  <= '0;
    end else begin
      rawBits <= rawNext;
      enBits  <= enNext;
      selBits <= selNext;
      prevLvl <= irqLines;
      irqOut  <= |(rawNext & enNext & ~selNext);
      fiqOut  <= |(rawNext & enNext & selNext);
      if (!ctrl.rdStb)      rdData <= '0;
      else if (ctrl.hiHalf) rdData <= {{(DATA_W-HI_W){1'b0}}, rdVal[NUM_LINES-1:DATA_W]};
      else                  rdData <= rdVal[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top
  import vic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic                 fiqOut
);
  ctrl_t                ctrl;
  logic [NUM_LINES-1:0] rawBits, enBits, selBits, senseBits, evtBits;

  vic_regctl u_ctl (.wrEn(wrEn), .rdEn(rdEn), .addr(addr), .ctrl(ctrl));

  vic_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData), .irqLines(irqLines),
    .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut),
    .rawBits(rawBits), .enBits(enBits), .selBits(selBits),
    .senseBits(senseBits), .evtBits(evtBits)
  );
endmodule

// File: rtl/vic_checker.sv
`timescale 1ns/1ps
module vic_checker
  import vic_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [NUM_LINES-1:0] irqLines,
  input logic                 irqOut,
  input logic                 fiqOut,
  input logic [NUM_LINES-1:0] rawBits,
  input logic [NUM_LINES-1:0] enBits,
  input logic [NUM_LINES-1:0] selBits,
  input logic [NUM_LINES-1:0] senseBits,
  input logic [NUM_LINES-1:0] evtBits
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!irqOut && !fiqOut && rawBits == '0));

  a_r3_level_track: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((rawBits & senseBits) ==
                     (senseBits & ~($past(irqLines) ^ $past(evtBits)))));

  a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !($past(wrEn) && $past(addr[7:3]) == 5'b11011))
      |-> (($past(rawBits) & ~senseBits & ~rawBits) == '0));

  a_r7_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'hA0) |=> ((enBits[DATA_W-1:0] & $past(wrData)) == $past(wrData)));

  a_r7_enable_clr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'hA8) |=> ((enBits[DATA_W-1:0] & $past(wrData)) == '0));

  a_r8_select_keep: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h98) |=> $stable(selBits[NUM_LINES-1:DATA_W]));

  a_r11_fast_out: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (fiqOut == |(rawBits & enBits & selBits)));
endmodule

bind vic_top vic_checker chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irqLines(irqLines), .irqOut(irqOut), .fiqOut(fiqOut),
  .rawBits(rawBits), .enBits(enBits), .selBits(selBits),
  .senseBits(senseBits), .evtBits(evtBits)
);

// File: tb/vic_top_test.sv
`timescale 1ns/1ps
module vic_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [50:0] irqLines = '0;
  logic [31:0] rdData;
  logic        irqOut, fiqOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vic_top uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
               .wrData(wrData), .irqLines(irqLines), .rdData(rdData),
               .irqOut(irqOut), .fiqOut(fiqOut));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1; addr = a;
    @(negedge clk); rdEn = 0; d = rdData;
  endtask

  task automatic setLine(input int n, input logic v);
    @(negedge clk); irqLines[n] = v;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 irqOut", {31'b0, irqOut}, 0);
    check("R1 fiqOut", {31'b0, fiqOut}, 0);
    rd(8'hC0, d); check("R1 sense lo", d, 32'hFFF8FFFF);
    rd(8'hC4, d); check("R1 R2 sense hi", d, 32'h1F07);
    rd(8'hC8, d); check("R1 both lo", d, 32'h00070000);
    rd(8'hCC, d); check("R1 both hi", d, 32'hF8);
    rd(8'hD0, d); check("R1 event lo", d, 32'hFFF8FFFF);
    rd(8'hD4, d); check("R1 event hi", d, 32'h5F07);
    rd(8'h90, d); check("R1 raw lo", d, 0);
    rd(8'hA0, d); check("R1 enable lo", d, 0);
  endtask

  task automatic testLevelRoute();
    logic [31:0] d;
    setLine(3, 1);
    rd(8'h90, d); check("R3 level raw set", d, 32'h8);
    check("R11 masked irq", {31'b0, irqOut}, 0);
    wr(8'hA0, 32'h8);
    check("R7 R11 irq after enable", {31'b0, irqOut}, 1);
    rd(8'h80, d); check("R10 irq status", d, 32'h8);
    setLine(3, 0);
    check("R3 R11 irq drops with level", {31'b0, irqOut}, 0);
    rd(8'h90, d); check("R3 level raw clear", d, 0);
    wr(8'h98, 32'h8);
    setLine(3, 1);
    check("R8 R11 fast out", {31'b0, fiqOut}, 1);
    check("R8 R11 normal out low", {31'b0, irqOut}, 0);
    rd(8'h88, d); check("R10 fiq status", d, 32'h8);
    wr(8'hA8, 32'h8);
    check("R7 fast out after clear", {31'b0, fiqOut}, 0);
    rd(8'hA0, d); check("R7 enable cleared", d, 0);
    rd(8'hA8, d); check("R12 write-only read", d, 0);
    wr(8'hD8, 32'h8);
    rd(8'h90, d); check("R6 level unaffected by edge clear", d, 32'h8);
    setLine(3, 0);
    wr(8'h98, 0);
  endtask

  task automatic testEdges();
    logic [31:0] d;
    @(negedge clk); irqLines[46] = 1;
    @(negedge clk); irqLines[46] = 0;
    @(negedge clk);
    rd(8'h94, d); check("R4 rising latched", d, 32'h4000);
    rd(8'hE4, d); check("R10 edge status", d, 32'h4000);
    rd(8'h90, d); check("R2 low word free of high bits", d, 0);
    wr(8'hDC, 32'h4000);
    rd(8'h94, d); check("R6 edge cleared", d, 0);
    setLine(45, 1);
    rd(8'h94, d); check("R4 falling line ignores rise", d, 0);
    setLine(45, 0);
    rd(8'h94, d); check("R4 falling latched", d, 32'h2000);
    wr(8'hDC, 32'h2000);
    setLine(16, 1);
    rd(8'h90, d); check("R5 both-edge rise", d, 32'h10000);
    wr(8'hD8, 32'h10000);
    rd(8'h90, d); check("R6 both-edge cleared", d, 0);
    setLine(16, 0);
    rd(8'h90, d); check("R5 both-edge fall", d, 32'h10000);
    wr(8'hD8, 32'h10000);
  endtask

  task automatic testSelectHalves();
    logic [31:0] d;
    wr(8'h98, 32'hAAAA5555);
    wr(8'h9C, 32'hFFFFFFFF);
    rd(8'h9C, d); check("R2 R8 select hi masked", d, 32'h7FFFF);
    rd(8'h98, d); check("R8 low kept after hi write", d, 32'hAAAA5555);
    wr(8'h98, 32'h1);
    rd(8'h9C, d); check("R8 hi kept after low write", d, 32'h7FFFF);
    rd(8'h98, d); check("R8 low replaced", d, 32'h1);
    wr(8'h98, 0); wr(8'h9C, 0);
  endtask

  task automatic testEventWrite();
    logic [31:0] d;
    wr(8'hD4, 32'hFFFFFFFF);
    rd(8'hD4, d); check("R9 event hi writable bits", d, 32'h7DF07);
    wr(8'hD0, 32'h0);
    rd(8'hD0, d); check("R9 event lo ignored", d, 32'hFFF8FFFF);
    setLine(48, 1);
    rd(8'h94, d); check("R9 R4 line 48 now rising", d, 32'h10000);
    wr(8'hDC, 32'h10000);
    setLine(48, 0);
    rd(8'h94, d); check("R9 R4 line 48 ignores fall", d, 0);
  endtask

  task automatic testIllegal();
    logic [31:0] d;
    rd(8'h40, d); check("R12 undefined offset", d, 0);
    rd(8'hD8, d); check("R12 edge clear read", d, 0);
    wr(8'hC0, 32'h0);
    rd(8'hC0, d); check("R12 sense not writable", d, 32'hFFF8FFFF);
    wr(8'hC8, 32'hFFFFFFFF);
    rd(8'hC8, d); check("R12 both-edge not writable", d, 32'h00070000);
    wr(8'h90, 32'hFFFFFFFF);
    rd(8'h90, d); check("R12 raw not writable", d, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testLevelRoute();
    testEdges();
    testSelectHalves();
    testEventWrite();
    testIllegal();
    finishRun();
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog got timeout exp completion");
    finishRun();
  end
endmodule